// File: doc/BRIEF.md
# Planar Framebuffer Scan-out Engine

This block streams 8-bit pixels for a 320x200, 256-colour raster out of a video memory organised as four byte-wide planes behind one shared address. One read returns a 32-bit word. Byte lane k of that word is plane k, and the four lanes are four horizontally adjacent pixels. The engine keeps a scan address and a row base. It latches a full word when a group of four pixels begins, and then shifts the word out one pixel per pixel-enable pulse, plane 0 first. After plane 3 it moves to the next address.

A frame strobe loads the programmable start address into both the row base and the scan address. It also captures the addressing mode. Each line strobe moves the row base 80 addresses further on. The start value always counts in plane addresses, so one step of it is four pixels and 80 steps are one row.

In planar (unchained) mode the scan address drives memory directly, and a page uses 16000 of the 65536 addresses. In chained mode each CPU byte was stored at its own linear address, so the engine reads at four times the scan address. The row stride for the start address stays 80 in both modes. All address arithmetic wraps modulo 65536.

Top module: `planar_scanout`

## Requirements
- R1: While reset is asserted, and until the first strobe after it, `rd_addr` is 0, `pix_valid` is 0 and `pix` is 0.
- R2: A `frame_start` pulse captures `start_addr` and `chain_mode`. From the next cycle the scan address equals the captured start value. Changes to `start_addr` or `chain_mode` between frame strobes have no effect.
- R3: With `chain_mode` captured as 0, `rd_addr` equals the scan address. With it captured as 1, `rd_addr` equals the scan address times 4, modulo 65536, so its two low bits are 0.
- R4: `rd_data` carries plane k in bits [8k+7:8k]. Successive accepted `pix_en` pulses emit plane 0, 1, 2, 3 of the current address. Each pixel appears on `pix` with `pix_valid` high in the cycle after its `pix_en`.
- R5: The scan address increases by one after the fourth pixel of a group is accepted. Without a strobe or such a fourth pixel, it holds its value.
- R6: A `line_start` pulse sets the row base and the scan address to the previous row base plus 80.
- R7: Scan and row addresses wrap modulo 65536: advancing from 65535 gives 0, and chained mapping of 16383+1 gives `rd_addr` 0.
- R8: In a cycle with `frame_start` or `line_start` high, `pix_en` is ignored and no pixel is produced. `frame_start` takes priority over `line_start`.
- R9: The four planes are sampled only on the first pixel of a group. A change of `rd_data` during pixels 1 to 3 does not alter them.
- R10: A strobe in the middle of a group abandons the rest of that group. The next pixel is plane 0 at the new address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_addr | input | 16 | Scan start, in plane addresses |
| chain_mode | input | 1 | 1 = chained byte-per-address layout, 0 = planar |
| frame_start | input | 1 | Top-of-frame strobe |
| line_start | input | 1 | Start-of-next-row strobe |
| pix_en | input | 1 | Pixel clock enable, one pixel per pulse |
| rd_addr | output | 16 | Plane memory read address |
| rd_data | input | 32 | Four planes read at `rd_addr`, plane k in byte k |
| pix | output | 8 | Pixel colour index |
| pix_valid | output | 1 | `pix` holds a new pixel this cycle |

## Verification
The bench uses the default parameters: 16-bit addresses, four 8-bit planes and a row stride of 80. Because the address width is 16, wrap-around is only a few pixels away when the frame starts near 65535 in planar mode or near 16383 in chained mode. The stride of 80 makes row arithmetic visible directly on `rd_addr`. The memory model is a function of the address, so every emitted byte can be predicted. A forced override of `rd_data` in the middle of a group shows whether the word was latched.

// File: rtl/pscan_pkg.sv
`timescale 1ns/1ps
package pscan_pkg;
  localparam int unsigned PIX_W    = 8;
  localparam int unsigned NPLANES  = 4;
  localparam int unsigned ADDR_W   = 16;
  localparam int unsigned ROW_STEP = 80;

  typedef struct packed {
    logic frame;
    logic line;
    logic pix;
  } strobe_t;
endpackage

// File: rtl/pscan_addr_gen.sv
`timescale 1ns/1ps
module pscan_addr_gen #(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned ROW_STEP = 80,
  parameter int unsigned NPLANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_i,
  input  logic              line_i,
  input  logic              step_i,
  input  logic [ADDR_W-1:0] start_i,
  input  logic              chain_i,
  output logic [ADDR_W-1:0] rd_addr_o
);
  localparam int unsigned SHIFT = $clog2(NPLANES);
  localparam logic [ADDR_W-1:0] STEP_A = ADDR_W'(ROW_STEP);
  localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'((1 << SHIFT) - 1);

  logic [ADDR_W-1:0] base_q, base_d;
  logic [ADDR_W-1:0] scan_q, scan_d;
  logic              chain_q, chain_d;
  logic              upd_en;

  assign upd_en = frame_i | line_i | step_i;

  always_comb begin
    base_d  = base_q;
    scan_d  = scan_q;
    chain_d = chain_q;
    if (frame_i) begin
      base_d  = start_i;
      scan_d  = start_i;
      chain_d = chain_i;
    end else if (line_i) begin
      base_d = base_q + STEP_A;
      scan_d = base_q + STEP_A;
    end else if (step_i) begin
      scan_d = scan_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      scan_q  <= '0;
      chain_q <= 1'b0;
    end else if (upd_en) begin
      base_q  <= base_d;
      scan_q  <= scan_d;
      chain_q <= chain_d;
    end
  end

  generate
    if (SHIFT == 0) begin : g_flat
      assign rd_addr_o = scan_q;
    end else begin : g_shift
      assign rd_addr_o = chain_q ? (scan_q << SHIFT) : scan_q;
    end
  endgenerate

  // R5
  scan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_i && !line_i && !step_i) |=> $stable(scan_q));

  // R6
  row_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_i && !frame_i) |=> (scan_q == ADDR_W'($past(base_q) + STEP_A)));

  // R3
  chain_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chain_q |-> ((rd_addr_o & LOW_MASK) == '0));

  // R2
  frame_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_i |=> (base_q == $past(start_i)));
endmodule

// File: rtl/pscan_plane_ser.sv
`timescale 1ns/1ps
module pscan_plane_ser #(
  parameter int unsigned PIX_W   = 8,
  parameter int unsigned NPLANES = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       restart_i,
  input  logic                       pix_en_i,
  input  logic [NPLANES*PIX_W-1:0]   rd_data_i,
  output logic                       step_o,
  output logic [PIX_W-1:0]           pix_o,
  output logic                       vld_o
);
  localparam int unsigned PH_W = (NPLANES > 1) ? $clog2(NPLANES) : 1;
  localparam logic [PH_W-1:0] LAST = PH_W'(NPLANES - 1);

  logic [NPLANES*PIX_W-1:0] hold_q, hold_d;
  logic [PH_W-1:0]          phase_q, phase_d;
  logic [PIX_W-1:0]         pix_q, pix_d;
  logic                     vld_q;
  logic                     take;
  logic                     first;
  logic [PIX_W-1:0]         lane [NPLANES];

  genvar g;
  generate
    for (g = 0; g < NPLANES; g++) begin : g_lane
      assign lane[g] = hold_q[g*PIX_W +: PIX_W];
    end
  endgenerate

  assign take   = pix_en_i & ~restart_i;
  assign first  = (phase_q == '0);
  assign step_o = take & (phase_q == LAST);

  always_comb begin
    phase_d = phase_q;
    hold_d  = hold_q;
    pix_d   = pix_q;
    if (restart_i) begin
      phase_d = '0;
    end else if (take) begin
      phase_d = (phase_q == LAST) ? '0 : phase_q + 1'b1;
      if (first) begin
        hold_d = rd_data_i;
        pix_d  = rd_data_i[PIX_W-1:0];
      end else begin
        pix_d  = lane[phase_q];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      hold_q  <= '0;
      pix_q   <= '0;
      vld_q   <= 1'b0;
    end else begin
      vld_q <= take;
      if (restart_i | take) begin
        phase_q <= phase_d;
        hold_q  <= hold_d;
        pix_q   <= pix_d;
      end
    end
  end

  assign pix_o = pix_q;
  assign vld_o = vld_q;

  // R8
  vld_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o |-> ($past(pix_en_i) && !$past(restart_i)));

  // R10
  phase_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> (phase_q == '0));
endmodule

// File: rtl/planar_scanout.sv
`timescale 1ns/1ps
module planar_scanout
  import pscan_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         start_addr,
  input  logic                      chain_mode,
  input  logic                      frame_start,
  input  logic                      line_start,
  input  logic                      pix_en,
  output logic [ADDR_W-1:0]         rd_addr,
  input  logic [NPLANES*PIX_W-1:0]  rd_data,
  output logic [PIX_W-1:0]          pix,
  output logic                      pix_valid
);
  logic [1:0] rst_sync_q;
  logic       rst_core_n;
  strobe_t    st;
  logic       step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  assign st = '{frame: frame_start, line: line_start, pix: pix_en};

  pscan_addr_gen #(
    .ADDR_W  (ADDR_W),
    .ROW_STEP(ROW_STEP),
    .NPLANES (NPLANES)
  ) u_addr (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .frame_i  (st.frame),
    .line_i   (st.line),
    .step_i   (step),
    .start_i  (start_addr),
    .chain_i  (chain_mode),
    .rd_addr_o(rd_addr)
  );

  pscan_plane_ser #(
    .PIX_W  (PIX_W),
    .NPLANES(NPLANES)
  ) u_ser (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .restart_i(st.frame | st.line),
    .pix_en_i (st.pix),
    .rd_data_i(rd_data),
    .step_o   (step),
    .pix_o    (pix),
    .vld_o    (pix_valid)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_core_n |-> (!pix_valid && rd_addr == '0));
endmodule

// File: tb/sim_planar_scanout.sv
`timescale 1ns/1ps
module sim_planar_scanout;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] start_addr;
  logic        chain_mode, frame_start, line_start, pix_en;
  logic [15:0] rd_addr;
  logic [31:0] rd_data;
  logic [7:0]  pix;
  logic        pix_valid;
  logic        ovr;
  int          n_chk = 0;
  int          n_bad = 0;

  always #2.5 clk = ~clk;

  function automatic logic [31:0] memw(input logic [15:0] a);
    logic [31:0] w;
    for (int k = 0; k < 4; k++)
      w[k*8 +: 8] = a[7:0] + 8'(a[15:8] * 3) + 8'(k * 8'h41);
    return w;
  endfunction

  assign rd_data = ovr ? 32'hA5A5_A5A5 : memw(rd_addr);

  planar_scanout u0 (
    .clk(clk), .rst_n(rst_n), .start_addr(start_addr), .chain_mode(chain_mode),
    .frame_start(frame_start), .line_start(line_start), .pix_en(pix_en),
    .rd_addr(rd_addr), .rd_data(rd_data), .pix(pix), .pix_valid(pix_valid)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_frame(input logic [15:0] s, input logic m);
    @(negedge clk); start_addr = s; chain_mode = m; frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
  endtask

  task automatic do_line();
    @(negedge clk); line_start = 1'b1;
    @(negedge clk); line_start = 1'b0;
  endtask

  task automatic emit(input logic [15:0] scan, input int plane, input logic m, input string req);
    logic [15:0] a;
    logic [31:0] w;
    a = m ? {scan[13:0], 2'b00} : scan;
    w = memw(a);
    @(negedge clk); pix_en = 1'b1;
    @(negedge clk); pix_en = 1'b0;
    check(pix_valid === 1'b1, req, {31'd0, pix_valid}, 32'd1);
    check(pix === w[plane*8 +: 8], req, {24'd0, pix}, {24'd0, w[plane*8 +: 8]});
  endtask

  task automatic t_reset();
    rst_n = 1'b0; start_addr = 16'h1234; chain_mode = 1'b0;
    frame_start = 1'b0; line_start = 1'b0; pix_en = 1'b0; ovr = 1'b0;
    repeat (3) @(negedge clk);
    check(rd_addr === 16'd0 && pix_valid === 1'b0, "R1 in reset", {rd_addr, 15'd0, pix_valid}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(rd_addr === 16'd0, "R1 rd_addr", {16'd0, rd_addr}, 32'd0);
    check(pix === 8'd0 && pix_valid === 1'b0, "R1 pix", {23'd0, pix_valid, pix}, 32'd0);
  endtask

  task automatic t_planar_row();
    do_frame(16'd100, 1'b0);
    check(rd_addr === 16'd100, "R2 start load", {16'd0, rd_addr}, 32'd100);
    for (int i = 0; i < 12; i++) emit(16'(100 + i / 4), i % 4, 1'b0, "R4 R5 planar order");
    check(rd_addr === 16'd103, "R5 advance", {16'd0, rd_addr}, 32'd103);
  endtask

  task automatic t_line_and_hold();
    do_line();
    check(rd_addr === 16'd180, "R6 row step", {16'd0, rd_addr}, 32'd180);
    for (int i = 0; i < 4; i++) emit(16'd180, i, 1'b0, "R6 row pixels");
    @(negedge clk); start_addr = 16'd5000; chain_mode = 1'b1;
    do_line();
    check(rd_addr === 16'd260, "R2 start ignored mid-frame", {16'd0, rd_addr}, 32'd260);
  endtask

  task automatic t_partial();
    emit(16'd260, 0, 1'b0, "R10 partial p0");
    emit(16'd260, 1, 1'b0, "R10 partial p1");
    do_line();
    check(rd_addr === 16'd340, "R10 line mid-group", {16'd0, rd_addr}, 32'd340);
    emit(16'd340, 0, 1'b0, "R10 restart at plane 0");
  endtask

  task automatic t_chained();
    do_frame(16'd80, 1'b1);
    check(rd_addr === 16'd320, "R3 chained map", {16'd0, rd_addr}, 32'd320);
    for (int i = 0; i < 8; i++) emit(16'(80 + i / 4), i % 4, 1'b1, "R3 chained pixels");
    check(rd_addr === 16'd328, "R3 chained advance", {16'd0, rd_addr}, 32'd328);
    do_line();
    check(rd_addr === 16'd640, "R3 chained row", {16'd0, rd_addr}, 32'd640);
  endtask

  task automatic t_wrap();
    do_frame(16'hFFFF, 1'b0);
    for (int i = 0; i < 4; i++) emit(16'hFFFF, i, 1'b0, "R7 top group");
    check(rd_addr === 16'd0, "R7 planar wrap", {16'd0, rd_addr}, 32'd0);
    emit(16'd0, 0, 1'b0, "R7 after wrap");
    do_frame(16'd16383, 1'b1);
    check(rd_addr === 16'hFFFC, "R7 chained top", {16'd0, rd_addr}, 32'hFFFC);
    for (int i = 0; i < 4; i++) emit(16'd16383, i, 1'b1, "R7 chained group");
    check(rd_addr === 16'd0, "R7 chained wrap", {16'd0, rd_addr}, 32'd0);
  endtask

  task automatic t_priority();
    @(negedge clk);
    start_addr = 16'd700; chain_mode = 1'b0;
    frame_start = 1'b1; line_start = 1'b1; pix_en = 1'b1;
    @(negedge clk);
    frame_start = 1'b0; line_start = 1'b0; pix_en = 1'b0;
    check(pix_valid === 1'b0, "R8 pix_en ignored", {31'd0, pix_valid}, 32'd0);
    check(rd_addr === 16'd700, "R8 frame wins", {16'd0, rd_addr}, 32'd700);
  endtask

  task automatic t_latch();
    emit(16'd700, 0, 1'b0, "R9 fetch");
    ovr = 1'b1;
    for (int i = 1; i < 4; i++) emit(16'd700, i, 1'b0, "R9 latched word");
    ovr = 1'b0;
    emit(16'd701, 0, 1'b0, "R9 next fetch");
  endtask

  initial begin
    t_reset();
    t_planar_row();
    t_line_and_hold();
    t_partial();
    t_chained();
    t_wrap();
    t_priority();
    t_latch();
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule